// File: doc/BRIEF.md
# Processor Package Sleep-State Sequencer

This block follows a processor package through its low-power states, starting from the shallowest state (Stop-Grant). It moves down through Sleep, Deep Sleep and Deeper Sleep, and it can reach an enhanced Deeper Sleep sub-state that is allowed only once the L2 cache is off. Three active-low request pins, a sleep pin, a deep pin and a deeper pin, together with an L2-off status flag, drive the moves. Every pin input passes through a two-flop synchroniser on an always-on reference clock. A state can only be entered from the state directly above it. When a request is not legal from the current state, the block ignores it and sets a sticky protocol-error flag.

For each state the block selects one of three 7-bit voltage-ID codes, all supplied as configuration inputs. When enabled, it requests the bus clock to stop while in the deep states. Snoop acceptance and interrupt latching are allowed only in Stop-Grant and Sleep. When the deep request is withdrawn, the block does not report Sleep straight away. It first waits a PLL relock window of a parameterised number of reference-clock cycles, and reports Sleep only after that window.

Top module: `sleep_seq_top`

## Requirements
- R1: A change on any request pin is first seen by the state machine after two synchronising flops, so the state output changes on the third rising clock edge after the pin changes.
- R2: The state output uses these codes: Stop-Grant 0, Sleep 1, Deep 2, Deeper 3, Enhanced 4, Relock 5. From Stop-Grant, asserting sleep (pin low) moves the block to Sleep. From Sleep, releasing sleep while no deeper request is active returns the block to Stop-Grant.
- R3: Deep is entered only from Sleep, and only when the deep pin is asserted while sleep is held. When `clkStopEn` is 1, `busClkStop` rises on the same edge that the state becomes Deep and stays high through the deep states. When `clkStopEn` is 0, `busClkStop` stays 0.
- R4: From Deep, releasing the deep pin while sleep is held and deeper is released enters Relock (code 5) for exactly RELOCK_CYCLES cycles, then the state becomes Sleep. `busClkStop` falls on the edge that Relock is entered.
- R5: From Deep, asserting deeper enters Enhanced (4) if `l2Off` is 1 and Deeper (3) otherwise. From either of those states, releasing deeper returns to Deep.
- R6: `vidOut` is `vidEnhanced` in Enhanced, `vidDeeper` in Deeper, and `vidNormal` in every other state. It changes one clock cycle after the state changes.
- R7: `snoopEn` and `intLatchEn` are 1 in Stop-Grant and Sleep, and 0 in Deep, Deeper, Enhanced and Relock.
- R8: An illegal input leaves the state unchanged and sets `protoErr`, which then stays set until reset. The illegal inputs are:
  - deep or deeper asserted in Stop-Grant;
  - deeper asserted in Sleep without deep;
  - sleep released in Sleep while deep or deeper is asserted;
  - sleep released in Deep;
  - sleep or deep released in Deeper or Enhanced;
  - sleep released, or deep or deeper asserted, during Relock.

  An illegal input during Relock does not change the length of the Relock window.
- R9: While reset is asserted, the block is in Stop-Grant with `vidOut` equal to `vidNormal`, `busClkStop` at 0, snoops enabled and `protoErr` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepPinN | input | 1 | Sleep request, active low, asynchronous |
| deepPinN | input | 1 | Deep request, active low, asynchronous |
| deeperPinN | input | 1 | Deeper request, active low, asynchronous |
| l2Off | input | 1 | L2 cache fully off, asynchronous |
| clkStopEn | input | 1 | Allow the bus-clock stop request |
| vidNormal | input | 7 | VID code for the non-deeper states |
| vidDeeper | input | 7 | VID code for Deeper |
| vidEnhanced | input | 7 | VID code for Enhanced (lowest voltage) |
| seqState | output | 3 | Current state code |
| vidOut | output | 7 | Selected VID code |
| busClkStop | output | 1 | Request to stop the bus clock |
| snoopEn | output | 1 | Snoops may be accepted |
| intLatchEn | output | 1 | Interrupts may be latched |
| protoErr | output | 1 | Sticky illegal-input flag |

## Verification
The bench builds the block with RELOCK_CYCLES set to 6 and two synchroniser stages. With that short window, a whole relock pass fits in a few cycles, which makes it practical to sweep every one of the 16 combinations of the three request pins and the L2 flag from each stable state, once with `clkStopEn` at 0 and once at 1. The bench derives the settled state, the error flag and the VID from a rule table that it builds from the requirements. Separate directed runs measure the relock length in cycles, the synchroniser latency and the one-cycle lag of the VID.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

  typedef enum logic [2:0] {
    ST_STOPGNT = 3'd0,
    ST_SLEEP   = 3'd1,
    ST_DEEP    = 3'd2,
    ST_DEEPER  = 3'd3,
    ST_ENH     = 3'd4,
    ST_RELOCK  = 3'd5
  } seqState_e;

  typedef enum logic [1:0] {
    VID_NORMAL = 2'd0,
    VID_DEEPER = 2'd1,
    VID_ENH    = 2'd2
  } vidSel_e;

  typedef struct packed {
    logic    timerLoad;
    logic    timerRun;
    logic    stopSet;
    logic    stopClr;
    logic    errSet;
    vidSel_e vidSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/sleep_seq_sync.sv
module sleep_seq_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[g] <= RESET_VAL;
        else       chain[g] <= din;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[g] <= RESET_VAL;
        else       chain[g] <= chain[g-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl
  import sleep_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sleepA,
  input  logic        deepA,
  input  logic        deeperA,
  input  logic        l2OffS,
  input  logic        timerDone,
  output seqState_e   state,
  output ctrlStrobe_t strobe
);

  seqState_e stateQ, stateD;
  logic      illegal;

  always_comb begin
    stateD  = stateQ;
    illegal = 1'b0;
    unique case (stateQ)
      ST_STOPGNT: begin
        if (deepA || deeperA) illegal = 1'b1;
        else if (sleepA)      stateD  = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (!sleepA) begin
          if (deepA || deeperA) illegal = 1'b1;
          else                  stateD  = ST_STOPGNT;
        end else if (deepA) begin
          stateD = ST_DEEP;
        end else if (deeperA) begin
          illegal = 1'b1;
        end
      end
      ST_DEEP: begin
        if (!sleepA)       illegal = 1'b1;
        else if (deeperA)  stateD  = l2OffS ? ST_ENH : ST_DEEPER;
        else if (!deepA)   stateD  = ST_RELOCK;
      end
      ST_DEEPER, ST_ENH: begin
        if (!sleepA || !deepA) illegal = 1'b1;
        else if (!deeperA)     stateD  = ST_DEEP;
      end
      ST_RELOCK: begin
        if (!sleepA || deepA || deeperA) illegal = 1'b1;
        if (timerDone) stateD = ST_SLEEP;
      end
      default: stateD = ST_STOPGNT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_STOPGNT;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe.timerLoad = (stateQ == ST_DEEP) && (stateD == ST_RELOCK);
    strobe.timerRun  = (stateQ == ST_RELOCK);
    strobe.stopSet   = (stateQ == ST_SLEEP) && (stateD == ST_DEEP);
    strobe.stopClr   = (stateD == ST_RELOCK) || (stateD == ST_SLEEP) || (stateD == ST_STOPGNT);
    strobe.errSet    = illegal;
    unique case (stateQ)
      ST_DEEPER: strobe.vidSel = VID_DEEPER;
      ST_ENH:    strobe.vidSel = VID_ENH;
      default:   strobe.vidSel = VID_NORMAL;
    endcase
  end

  assign state = stateQ;

  assert_deep_entry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_DEEP && $past(stateQ) != ST_DEEP) |->
      ($past(stateQ) == ST_SLEEP || $past(stateQ) == ST_DEEPER || $past(stateQ) == ST_ENH));

  assert_sleep_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SLEEP && $past(stateQ) != ST_SLEEP) |->
      ($past(stateQ) == ST_STOPGNT || $past(stateQ) == ST_RELOCK));

  assert_deeper_from_deep_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_DEEPER || stateQ == ST_ENH) && $past(stateQ) != stateQ) |->
      $past(stateQ) == ST_DEEP);

  assert_illegal_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (illegal && stateQ != ST_RELOCK) |=> $stable(stateQ));

endmodule

// File: rtl/sleep_seq_dp.sv
module sleep_seq_dp
  import sleep_seq_pkg::*;
#(
  parameter int RELOCK_CYCLES = 3750,
  parameter int VID_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic             clkStopEn,
  input  logic [VID_W-1:0] vidNormal,
  input  logic [VID_W-1:0] vidDeeper,
  input  logic [VID_W-1:0] vidEnhanced,
  output logic             timerDone,
  output logic             busClkStop,
  output logic             protoErr,
  output logic [VID_W-1:0] vidOut
);

  localparam int TW = (RELOCK_CYCLES > 1) ? $clog2(RELOCK_CYCLES) : 1;
  localparam logic [TW-1:0] LOAD_VAL = TW'(RELOCK_CYCLES - 1);

  logic [TW-1:0]    timer;
  logic [VID_W-1:0] vidNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 timer <= '0;
    else if (strobe.timerLoad) timer <= LOAD_VAL;
    else if (strobe.timerRun && timer != '0) timer <= timer - 1'b1;
  end

  assign timerDone = (timer == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            busClkStop <= 1'b0;
    else if (strobe.stopClr)              busClkStop <= 1'b0;
    else if (strobe.stopSet && clkStopEn) busClkStop <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              protoErr <= 1'b0;
    else if (strobe.errSet) protoErr <= 1'b1;
  end

  always_comb begin
    unique case (strobe.vidSel)
      VID_DEEPER: vidNext = vidDeeper;
      VID_ENH:    vidNext = vidEnhanced;
      default:    vidNext = vidNormal;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vidOut <= vidNormal;
    else       vidOut <= vidNext;
  end

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

  assert_timer_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    timer <= LOAD_VAL);

  assert_stop_gated_R3: assert property (@(posedge clk) disable iff (!rstN)
    busClkStop |-> clkStopEn);

endmodule

// File: rtl/sleep_seq_top.sv
module sleep_seq_top
  import sleep_seq_pkg::*;
#(
  parameter int RELOCK_CYCLES = 3750,
  parameter int SYNC_STAGES = 2,
  parameter int VID_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sleepPinN,
  input  logic             deepPinN,
  input  logic             deeperPinN,
  input  logic             l2Off,
  input  logic             clkStopEn,
  input  logic [VID_W-1:0] vidNormal,
  input  logic [VID_W-1:0] vidDeeper,
  input  logic [VID_W-1:0] vidEnhanced,
  output logic [2:0]       seqState,
  output logic [VID_W-1:0] vidOut,
  output logic             busClkStop,
  output logic             snoopEn,
  output logic             intLatchEn,
  output logic             protoErr
);

  logic [3:0]  pinsRaw, pinsSync;
  seqState_e   state;
  ctrlStrobe_t strobe;
  logic        timerDone;

  assign pinsRaw = {l2Off, deeperPinN, deepPinN, sleepPinN};

  sleep_seq_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RESET_VAL(4'b0111)) u_sync (
    .clk(clk), .rstN(rstN), .din(pinsRaw), .dout(pinsSync)
  );

  sleep_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .sleepA(~pinsSync[0]), .deepA(~pinsSync[1]), .deeperA(~pinsSync[2]),
    .l2OffS(pinsSync[3]), .timerDone(timerDone),
    .state(state), .strobe(strobe)
  );

  sleep_seq_dp #(.RELOCK_CYCLES(RELOCK_CYCLES), .VID_W(VID_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .clkStopEn(clkStopEn),
    .vidNormal(vidNormal), .vidDeeper(vidDeeper), .vidEnhanced(vidEnhanced),
    .timerDone(timerDone), .busClkStop(busClkStop), .protoErr(protoErr),
    .vidOut(vidOut)
  );

  assign seqState   = state;
  assign snoopEn    = (state == ST_STOPGNT) || (state == ST_SLEEP);
  assign intLatchEn = snoopEn;

  assert_quiet_when_stopped_R7: assert property (@(posedge clk) disable iff (!rstN)
    busClkStop |-> !snoopEn);

endmodule

// File: tb/sleep_seq_top_tb.sv
`timescale 1ns/1ps
module sleep_seq_top_tb;

  localparam int RELOCK = 6;
  localparam logic [6:0] V_NORM = 7'h2A, V_DPR = 7'h15, V_ENH = 7'h05;

  logic clk = 1'b0, rstN = 1'b0;
  logic sleepPinN = 1'b1, deepPinN = 1'b1, deeperPinN = 1'b1, l2Off = 1'b0, clkStopEn = 1'b0;
  logic [2:0] seqState;
  logic [6:0] vidOut;
  logic busClkStop, snoopEn, intLatchEn, protoErr;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sleep_seq_top #(.RELOCK_CYCLES(RELOCK), .SYNC_STAGES(2), .VID_W(7)) u_dut (
    .clk(clk), .rstN(rstN), .sleepPinN(sleepPinN), .deepPinN(deepPinN),
    .deeperPinN(deeperPinN), .l2Off(l2Off), .clkStopEn(clkStopEn),
    .vidNormal(V_NORM), .vidDeeper(V_DPR), .vidEnhanced(V_ENH),
    .seqState(seqState), .vidOut(vidOut), .busClkStop(busClkStop),
    .snoopEn(snoopEn), .intLatchEn(intLatchEn), .protoErr(protoErr)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input bit s, input bit d, input bit r, input bit l);
    sleepPinN = ~s; deepPinN = ~d; deeperPinN = ~r; l2Off = l;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset(input bit stopEn);
    rstN = 1'b0;
    drive(0, 0, 0, 0);
    clkStopEn = stopEn;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic reach(input int st, input bit stopEn);
    doReset(stopEn);
    if (st >= 1) begin drive(1, 0, 0, 0); settle(); end
    if (st >= 2) begin drive(1, 1, 0, 0); settle(); end
    if (st == 3) begin drive(1, 1, 1, 0); settle(); end
    if (st == 4) begin drive(1, 1, 1, 1); settle(); end
  endtask

  function automatic int vidFor(input int st);
    if (st == 3) return int'(V_DPR);
    if (st == 4) return int'(V_ENH);
    return int'(V_NORM);
  endfunction

  function automatic void model(input int st, input bit s, input bit d, input bit r,
                                input bit l, output int ns, output bit e);
    ns = st; e = 1'b0;
    case (st)
      0: if (d || r) e = 1'b1; else if (s) ns = 1;
      1: if (!s) begin if (d || r) e = 1'b1; else ns = 0; end
         else if (d) ns = 2;
         else if (r) e = 1'b1;
      2: if (!s) e = 1'b1; else if (r) ns = l ? 4 : 3; else if (!d) ns = 5;
      3, 4: if (!s || !d) e = 1'b1; else if (!r) ns = 2;
      5: begin if (!s || d || r) e = 1'b1; ns = 1; end
      default: ns = 0;
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int n;
    // R9 reset state
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 state", seqState, 0);
    check("R9 vid", vidOut, V_NORM);
    check("R9 stop", busClkStop, 0);
    check("R9 snoop", snoopEn, 1);
    check("R9 err", protoErr, 0);

    // R1 synchroniser latency
    doReset(1'b0);
    drive(1, 0, 0, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 before third edge", seqState, 0);
    @(posedge clk);
    @(negedge clk);
    check("R1 at third edge", seqState, 1);

    // R6 one-cycle VID lag
    reach(2, 1'b1);
    drive(1, 1, 1, 0);
    settle();
    check("R5 deeper entry", seqState, 3);
    check("R6 vid lags state", vidOut, V_NORM);
    @(negedge clk);
    check("R6 vid updated", vidOut, V_DPR);

    // R4 relock length and clock restart
    reach(2, 1'b1);
    check("R3 stop raised", busClkStop, 1);
    drive(1, 0, 0, 0);
    settle();
    check("R4 stop dropped", busClkStop, 0);
    n = 0;
    while (seqState == 3'd5 && n < 100) begin
      n++;
      @(negedge clk);
    end
    check("R4 relock cycles", n, RELOCK);
    check("R4 then sleep", seqState, 1);
    check("R4 clean relock", protoErr, 0);

    // R8 disturbance during relock
    reach(2, 1'b0);
    drive(1, 0, 0, 0);
    settle();
    check("R4 relock entered", seqState, 5);
    drive(1, 0, 1, 0);
    @(negedge clk);
    drive(1, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R8 relock length unchanged", seqState, 5);
    repeat (12) @(negedge clk);
    check("R8 relock error", protoErr, 1);
    check("R8 relock still ends in sleep", seqState, 1);

    // Sweep: every input combination from each stable state, both stop settings
    for (int stopEn = 0; stopEn < 2; stopEn++) begin
      for (int st = 0; st < 5; st++) begin
        for (int v = 0; v < 16; v++) begin
          bit s, d, r, l, e, errAcc;
          int cur, ns;
          string tag;
          s = v[0]; d = v[1]; r = v[2]; l = v[3];
          cur = st; errAcc = 1'b0;
          for (int k = 0; k < 8; k++) begin
            model(cur, s, d, r, l, ns, e);
            errAcc |= e;
            if (ns == cur) break;
            cur = ns;
          end
          case (st)
            0: tag = "R2";
            1: tag = "R3";
            default: tag = "R5";
          endcase
          reach(st, stopEn[0]);
          drive(s, d, r, l);
          repeat (20) @(negedge clk);
          check({tag, " sweep state"}, seqState, cur);
          check("R8 sweep err", protoErr, errAcc);
          check("R7 sweep snoop", snoopEn, (cur <= 1) ? 1 : 0);
          check("R7 sweep intlatch", intLatchEn, (cur <= 1) ? 1 : 0);
          check("R3 sweep stop", busClkStop, (stopEn == 1 && cur >= 2 && cur <= 4) ? 1 : 0);
          check("R6 sweep vid", vidOut, vidFor(cur));
        end
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule